// File: doc/BRIEF.md
# Opcode-Steered 16-bit Arithmetic and Logic Unit

This block computes the result of one arithmetic, logic, shift, rotate or byte-exchange operation on two 16-bit operands in the same cycle, and keeps a seven-bit condition register that is updated on the following clock edge. It sits between a register file and the instruction sequencer. The sequencer hands over the raw 8-bit opcode, the destination operand, the source operand and the current carry. The block returns the new destination value at once, together with a write enable for each condition bit.

There is no separate decoder in front of the adder. Opcode bit 5 turns the adder into a subtractor, and opcode bit 4 replaces the source operand with the constant one. Shift and rotate share one datapath, and opcode bit 4 decides whether the bit that enters the word comes from the carry or from the other end of the word. Besides the usual carry, the adder reports the carry (or borrow) at the quarter, half and three-quarter points of the word.

Condition bits in `flags_o` and `flag_wr_o`: bit 0 carry (C), bit 1 quarter carry (QC), bit 2 half carry (HC), bit 3 three-quarter carry (TC), bit 4 zero (Z), bit 5 negative (N), bit 6 signed overflow (O).

Top module: `opalu_top`

## Requirements
- R1: Opcode 0x45 gives dst+src, 0x55 gives dst+1, 0x65 gives dst-src and 0x75 gives dst-1, all modulo 2^16, on `result_o` in the same cycle.
- R2: For these four opcodes C is the carry out of bit 15 for add and increment, and for subtract and decrement it is the borrow: set exactly when the unsigned subtrahend is larger than dst.
- R3: For these four opcodes QC, HC and TC are the carry (add, increment) or borrow (subtract, decrement) out of bits 3, 7 and 11, meaning out of the low 4, 8 and 12 bits taken as unsigned numbers.
- R4: For these four opcodes Z is set when the result is zero, N copies result bit 15, O is set when the signed two's-complement result does not fit in 16 bits, and all seven write enables are 1.
- R5: Opcodes 0x40, 0x41, 0x42 and 0x43 give ~dst, dst^src, dst&src and dst|src. Only the Z enable is 1, and Z is set when the result is zero.
- R6: Opcode 0x46 shifts dst left by one, puts the incoming carry into bit 0 and gives old bit 15 as the new C. Only the C and Z enables are 1.
- R7: Opcode 0x47 shifts dst right by one, puts the incoming carry into bit 15 and gives old bit 0 as the new C. Only the C and Z enables are 1.
- R8: Opcode 0x56 rotates dst left by one and 0x57 rotates it right by one. No write enable is 1 and the condition register keeps its value.
- R9: Opcode 0x48 exchanges the upper and lower byte of dst. No write enable is 1 and the condition register keeps its value.
- R10: Every other opcode puts dst unchanged on `result_o`. All write enables are 0 and the condition register keeps its value.
- R11: On each rising clock edge, a condition bit whose enable is 1 takes its new value and all other bits hold. An active-low reset clears all seven bits. `carry_i` never acts on the condition register directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the condition register |
| op_i | input | 8 | Raw opcode |
| dst_i | input | 16 | Destination operand |
| src_i | input | 16 | Source operand |
| carry_i | input | 1 | Current carry, used by the shifts |
| result_o | output | 16 | New destination value (combinational) |
| flag_wr_o | output | 7 | Per-bit condition write enables (combinational) |
| flags_o | output | 7 | Registered condition bits |

## Verification
The only internal state is the condition register. A bit that is written when it should hold, or that holds when it should be written, shows on `flags_o` one clock edge after the offending opcode. The bench compares that register against a behavioural model after every edge, so an error in it is caught within one cycle. Mistakes in the datapath or the opcode steering show up on `result_o` and `flag_wr_o` in the same cycle. For that reason every opcode from 0x00 to 0xFF is applied, together with the carry and borrow corners at each quarter boundary and the signed limits.

// File: rtl/opalu_pkg.sv
package opalu_pkg;
    localparam int FLAG_N = 7;
    localparam int F_C  = 0;
    localparam int F_QC = 1;
    localparam int F_HC = 2;
    localparam int F_TC = 3;
    localparam int F_Z  = 4;
    localparam int F_N  = 5;
    localparam int F_O  = 6;

    localparam logic [7:0] OP_NOT  = 8'h40;
    localparam logic [7:0] OP_XOR  = 8'h41;
    localparam logic [7:0] OP_AND  = 8'h42;
    localparam logic [7:0] OP_OR   = 8'h43;
    localparam logic [7:0] OP_ADD  = 8'h45;
    localparam logic [7:0] OP_SHL  = 8'h46;
    localparam logic [7:0] OP_SHR  = 8'h47;
    localparam logic [7:0] OP_SWAP = 8'h48;
    localparam logic [7:0] OP_INC  = 8'h55;
    localparam logic [7:0] OP_ROL  = 8'h56;
    localparam logic [7:0] OP_ROR  = 8'h57;
    localparam logic [7:0] OP_SUB  = 8'h65;
    localparam logic [7:0] OP_DEC  = 8'h75;

    typedef enum logic [2:0] {
        CLS_NONE, CLS_ARITH, CLS_LOGIC, CLS_SHIFT, CLS_ROT, CLS_SWAP
    } op_class_e;

    function automatic op_class_e classify(input logic [7:0] op);
        case (op)
            OP_ADD, OP_INC, OP_SUB, OP_DEC:  classify = CLS_ARITH;
            OP_NOT, OP_XOR, OP_AND, OP_OR:   classify = CLS_LOGIC;
            OP_SHL, OP_SHR:                  classify = CLS_SHIFT;
            OP_ROL, OP_ROR:                  classify = CLS_ROT;
            OP_SWAP:                         classify = CLS_SWAP;
            default:                         classify = CLS_NONE;
        endcase
    endfunction
endpackage

// File: rtl/opalu_arith.sv
module opalu_arith #(
    parameter int W     = 16,
    parameter int SEG_N = 4
) (
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic             sub_i,
    input  logic             one_i,
    output logic [W-1:0]     sum_o,
    output logic [SEG_N-1:0] cy_o,
    output logic             ovf_o
);
    localparam int SEG_W = W / SEG_N;

    logic [W-1:0] b_sel;
    logic [W-1:0] b_eff;

    assign b_sel = one_i ? W'(1) : b_i;
    assign b_eff = sub_i ? ~b_sel : b_sel;

    genvar g;
    generate
        for (g = 1; g <= SEG_N; g++) begin : g_seg
            localparam int PW = g * SEG_W;
            logic [PW:0] part;
            assign part = {1'b0, a_i[PW-1:0]} + {1'b0, b_eff[PW-1:0]} + {{PW{1'b0}}, sub_i};
            assign cy_o[g-1] = part[PW] ^ sub_i;
            if (g == SEG_N) begin : g_top
                assign sum_o = part[PW-1:0];
            end
        end
    endgenerate

    assign ovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/opalu_bitops.sv
module opalu_bitops #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   lsel_i,
    input  logic         right_i,
    input  logic         wrap_i,
    input  logic         cin_i,
    output logic [W-1:0] logic_o,
    output logic [W-1:0] shift_o,
    output logic         cout_o,
    output logic [W-1:0] swap_o
);
    localparam int HW = W / 2;

    logic fill;

    always_comb begin
        case (lsel_i)
            2'd0:    logic_o = ~a_i;
            2'd1:    logic_o = a_i ^ b_i;
            2'd2:    logic_o = a_i & b_i;
            default: logic_o = a_i | b_i;
        endcase
    end

    always_comb begin
        if (right_i) begin
            fill    = wrap_i ? a_i[0] : cin_i;
            shift_o = {fill, a_i[W-1:1]};
            cout_o  = a_i[0];
        end else begin
            fill    = wrap_i ? a_i[W-1] : cin_i;
            shift_o = {a_i[W-2:0], fill};
            cout_o  = a_i[W-1];
        end
    end

    assign swap_o = {a_i[HW-1:0], a_i[W-1:HW]};
endmodule

// File: rtl/opalu_top.sv
module opalu_top
    import opalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        op_i,
    input  logic [W-1:0]      dst_i,
    input  logic [W-1:0]      src_i,
    input  logic              carry_i,
    output logic [W-1:0]      result_o,
    output logic [FLAG_N-1:0] flag_wr_o,
    output logic [FLAG_N-1:0] flags_o
);
    localparam int SEG_N = 4;

    typedef struct packed {
        logic [W-1:0]      res;
        logic [FLAG_N-1:0] wr;
        logic [FLAG_N-1:0] val;
    } alu_out_t;

    alu_out_t          nx;
    logic [FLAG_N-1:0] flags_d, flags_q;
    op_class_e         cls;

    logic [W-1:0]     ar_sum;
    logic [SEG_N-1:0] ar_cy;
    logic             ar_ovf;
    logic [W-1:0]     bo_logic, bo_shift, bo_swap;
    logic             bo_cout;

    opalu_arith #(.W(W), .SEG_N(SEG_N)) u_arith (
        .a_i   (dst_i),
        .b_i   (src_i),
        .sub_i (op_i[5]),
        .one_i (op_i[4]),
        .sum_o (ar_sum),
        .cy_o  (ar_cy),
        .ovf_o (ar_ovf)
    );

    opalu_bitops #(.W(W)) u_bitops (
        .a_i     (dst_i),
        .b_i     (src_i),
        .lsel_i  (op_i[1:0]),
        .right_i (op_i[0]),
        .wrap_i  (op_i[4]),
        .cin_i   (carry_i),
        .logic_o (bo_logic),
        .shift_o (bo_shift),
        .cout_o  (bo_cout),
        .swap_o  (bo_swap)
    );

    assign cls = classify(op_i);

    always_comb begin
        nx     = '0;
        nx.res = dst_i;
        case (cls)
            CLS_ARITH: begin
                nx.res      = ar_sum;
                nx.wr       = '1;
                nx.val[F_QC] = ar_cy[0];
                nx.val[F_HC] = ar_cy[1];
                nx.val[F_TC] = ar_cy[2];
                nx.val[F_C]  = ar_cy[3];
                nx.val[F_Z]  = (ar_sum == '0);
                nx.val[F_N]  = ar_sum[W-1];
                nx.val[F_O]  = ar_ovf;
            end
            CLS_LOGIC: begin
                nx.res      = bo_logic;
                nx.wr[F_Z]  = 1'b1;
                nx.val[F_Z] = (bo_logic == '0);
            end
            CLS_SHIFT: begin
                nx.res      = bo_shift;
                nx.wr[F_C]  = 1'b1;
                nx.wr[F_Z]  = 1'b1;
                nx.val[F_C] = bo_cout;
                nx.val[F_Z] = (bo_shift == '0);
            end
            CLS_ROT:  nx.res = bo_shift;
            CLS_SWAP: nx.res = bo_swap;
            default:  nx.res = dst_i;
        endcase
        flags_d = (flags_q & ~nx.wr) | (nx.val & nx.wr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign result_o  = nx.res;
    assign flag_wr_o = nx.wr;
    assign flags_o   = flags_q;
endmodule

// File: rtl/opalu_checker.sv
module opalu_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [7:0]   op_i,
    input logic [W-1:0] dst_i,
    input logic         carry_i,
    input logic [W-1:0] result_o,
    input logic [6:0]   flag_wr_o,
    input logic [6:0]   flags_o
);
    localparam int HW = W / 2;

    p_hold_unwritten_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flag_wr_o) == 7'd0) |-> $stable(flags_o));

    p_zero_tracks_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flag_wr_o[4])) |-> (flags_o[4] == ($past(result_o) == '0)));

    p_logic_only_z_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i inside {8'h40, 8'h41, 8'h42, 8'h43}) |-> (flag_wr_o == 7'b0010000));

    p_shl_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 8'h46) |=> (flags_o[0] == $past(dst_i[W-1])));

    p_shr_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 8'h47) |-> (result_o[W-1] == carry_i && flag_wr_o == 7'b0010001));

    p_rol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 8'h56) |-> (result_o == {dst_i[W-2:0], dst_i[W-1]} && flag_wr_o == 7'd0));

    p_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 8'h48) |-> (result_o == {dst_i[HW-1:0], dst_i[W-1:HW]} && flag_wr_o == 7'd0));

    p_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[7:6] != 2'b01) |-> (result_o == dst_i && flag_wr_o == 7'd0));
endmodule

bind opalu_top opalu_checker #(.W(W)) u_opalu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .dst_i     (dst_i),
    .carry_i   (carry_i),
    .result_o  (result_o),
    .flag_wr_o (flag_wr_o),
    .flags_o   (flags_o)
);

// File: tb/opalu_top_test.sv
module opalu_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_i = 8'h00;
    logic [15:0] dst_i = '0;
    logic [15:0] src_i = '0;
    logic        carry_i = 1'b0;
    logic [15:0] result_o;
    logic [6:0]  flag_wr_o;
    logic [6:0]  flags_o;

    int          n_run = 0;
    int          n_fail = 0;
    logic [6:0]  exp_flags = '0;
    logic [31:0] rng = 32'h1234_5678;
    bit          finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    opalu_top uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .dst_i(dst_i), .src_i(src_i),
        .carry_i(carry_i), .result_o(result_o), .flag_wr_o(flag_wr_o), .flags_o(flags_o)
    );

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'h45, 8'h55, 8'h65, 8'h75: tag_of = "R1";
            8'h40, 8'h41, 8'h42, 8'h43: tag_of = "R5";
            8'h46: tag_of = "R6";
            8'h47: tag_of = "R7";
            8'h56, 8'h57: tag_of = "R8";
            8'h48: tag_of = "R9";
            default: tag_of = "R10";
        endcase
    endfunction

    task automatic model(input logic [7:0] op, input int a, input int b, input bit cin,
                         output int res, output logic [6:0] wr, output logic [6:0] val);
        int  bb, sa, sb, sr;
        bit  subm;
        res = a; wr = '0; val = '0;
        if (op == 8'h45 || op == 8'h55 || op == 8'h65 || op == 8'h75) begin
            bb   = (op == 8'h55 || op == 8'h75) ? 1 : b;
            subm = (op == 8'h65 || op == 8'h75);
            sa = (a >= 32768) ? a - 65536 : a;
            sb = (bb >= 32768) ? bb - 65536 : bb;
            if (subm) begin
                res    = (a - bb + 65536) % 65536;
                sr     = sa - sb;
                val[0] = a < bb;
                val[1] = (a % 16) < (bb % 16);
                val[2] = (a % 256) < (bb % 256);
                val[3] = (a % 4096) < (bb % 4096);
            end else begin
                res    = (a + bb) % 65536;
                sr     = sa + sb;
                val[0] = (a + bb) > 65535;
                val[1] = (a % 16 + bb % 16) > 15;
                val[2] = (a % 256 + bb % 256) > 255;
                val[3] = (a % 4096 + bb % 4096) > 4095;
            end
            val[4] = (res == 0);
            val[5] = res >= 32768;
            val[6] = (sr > 32767) || (sr < -32768);
            wr = 7'h7F;
        end else if (op == 8'h40) begin res = 65535 - a; wr = 7'h10; val[4] = res == 0;
        end else if (op == 8'h41) begin res = a ^ b;      wr = 7'h10; val[4] = res == 0;
        end else if (op == 8'h42) begin res = a & b;      wr = 7'h10; val[4] = res == 0;
        end else if (op == 8'h43) begin res = a | b;      wr = 7'h10; val[4] = res == 0;
        end else if (op == 8'h46) begin
            res = ((a * 2) % 65536) + (cin ? 1 : 0); wr = 7'h11;
            val[0] = a >= 32768; val[4] = res == 0;
        end else if (op == 8'h47) begin
            res = (a / 2) + (cin ? 32768 : 0); wr = 7'h11;
            val[0] = (a % 2) == 1; val[4] = res == 0;
        end else if (op == 8'h56) begin res = ((a * 2) % 65536) + (a / 32768);
        end else if (op == 8'h57) begin res = (a / 2) + ((a % 2) * 32768);
        end else if (op == 8'h48) begin res = (a % 256) * 256 + (a / 256);
        end
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b,
                        input bit cin, input string tag);
        int         res;
        logic [6:0] wr, val;
        @(negedge clk);
        op_i = op; dst_i = a; src_i = b; carry_i = cin;
        #1;
        model(op, int'(a), int'(b), cin, res, wr, val);
        check(tag, "result", int'(result_o), res);
        check(tag, "write enables", int'(flag_wr_o), int'(wr));
        exp_flags = (exp_flags & ~wr) | (val & wr);
        @(negedge clk);
        check((wr == 0) ? tag : "R11", "flags", int'(flags_o), int'(exp_flags));
    endtask

    function automatic logic [15:0] next_rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng[15:0];
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] ra, rb;
        // R11: reset clears, carry_i alone does not write
        carry_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R11", "reset flags", int'(flags_o), 0);
        rst_n = 1'b1;
        op_i = 8'h00;
        @(negedge clk);
        check("R11", "flags after idle edge", int'(flags_o), 0);

        // R1 R2 R3 R4 corners
        step(8'h45, 16'hFFFF, 16'h0001, 0, "R2");
        step(8'h45, 16'h7FFF, 16'h0001, 0, "R4");
        step(8'h45, 16'h000F, 16'h0001, 0, "R3");
        step(8'h45, 16'h00F0, 16'h0010, 0, "R3");
        step(8'h45, 16'h0F00, 16'h0100, 0, "R3");
        step(8'h55, 16'hFFFF, 16'hABCD, 0, "R1");
        step(8'h65, 16'h0000, 16'h0001, 0, "R2");
        step(8'h65, 16'h8000, 16'h0001, 0, "R4");
        step(8'h65, 16'h1234, 16'h1234, 0, "R4");
        step(8'h65, 16'h0100, 16'h0001, 0, "R3");
        step(8'h75, 16'h0000, 16'h5555, 0, "R1");
        step(8'h75, 16'h1000, 16'h0000, 0, "R3");
        // R5 logic, Z only
        step(8'h40, 16'hFFFF, 16'h0000, 0, "R5");
        step(8'h41, 16'hA5A5, 16'hA5A5, 0, "R5");
        step(8'h42, 16'hF0F0, 16'h0FF0, 0, "R5");
        step(8'h43, 16'h0000, 16'h8001, 0, "R5");
        // R6 R7 shifts through carry
        step(8'h46, 16'h8000, 16'h0000, 0, "R6");
        step(8'h46, 16'h4001, 16'h0000, 1, "R6");
        step(8'h47, 16'h0001, 16'h0000, 0, "R7");
        step(8'h47, 16'h0002, 16'h0000, 1, "R7");
        // R8 R9 no flag change, on a non-zero register
        step(8'h65, 16'h0000, 16'h7FFF, 0, "R2");
        step(8'h56, 16'h8001, 16'h0000, 0, "R8");
        step(8'h57, 16'h8001, 16'h0000, 1, "R8");
        step(8'h48, 16'h12AB, 16'h0000, 0, "R9");
        step(8'h00, 16'hBEEF, 16'hFFFF, 1, "R10");
        step(8'h44, 16'h0000, 16'hFFFF, 1, "R10");
        // sweep every opcode with varied data
        for (int op = 0; op < 256; op++) begin
            ra = next_rnd();
            rb = next_rnd();
            step(8'(op), ra, rb, ra[3], tag_of(8'(op)));
        end
        for (int k = 0; k < 200; k++) begin
            logic [7:0] ops [13] = '{8'h40, 8'h41, 8'h42, 8'h43, 8'h45, 8'h46, 8'h47,
                                     8'h48, 8'h55, 8'h56, 8'h57, 8'h65, 8'h75};
            ra = next_rnd();
            rb = next_rnd();
            step(ops[k % 13], ra, rb, rb[7], tag_of(ops[k % 13]));
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule